// File: doc/BRIEF.md
# Front-Panel Status LED Encoder

This block chooses what two front-panel indicators of a power module show and produces the timed drive levels for them. The input indicator is a single green lamp. The output indicator is a two-colour lamp with green and yellow dies. Its inputs are condition flags that are already synchronous to the clock:

- whether the input line is in range, and whether it is faulted;
- whether the bootloader is running;
- the causes for which the output is disabled;
- an out-of-regulation flag;
- the latched shutdown causes;
- the two warning classes.

The block picks the single most important active condition by a fixed ranking. For that condition it shows a solid colour, a plain on/off blink, or an alternating yellow/green pattern.

Blink timing comes from a 1 ms tick that a prescaler derives from the clock. Each blink period is split into six equal slots, and each slot lasts a parameterised number of ticks. Symmetric patterns use three slots of each kind. The over-temperature pattern uses four yellow slots and two green slots. Whenever the selected indication of either lamp changes, the prescaler and the slot sequence restart, so a new pattern always begins at its first slot.

Top module: `panel_led_encoder`

## Requirements
- R1: While `rst_n` is low, all three lamp outputs are 0. They stay 0 until the third rising clock edge after `rst_n` rises. From that edge on, they show the selected indication starting at slot 0.
- R2: The output lamp shows only the highest-ranked active condition, in this order:
  1. bootload (`boot_active`);
  2. any bit of `shut_cause`;
  3. disabled, meaning any bit of `dis_cause`, `out_of_reg`, `in_fault`, or `in_range` low;
  4. `ot_warn`;
  5. `fan_warn`;
  6. normal.
- R3: Outside bootload, `in_led_g` is 1 exactly when `in_range` is 1 and `in_fault` is 0, and 0 otherwise.
- R4: In bootload, `in_led_g` and `out_led_g` are 1 in slots 0 to 2 and 0 in slots 3 to 5, and `out_led_y` is 0.
- R5: In shutdown, the output lamp is solid yellow (`out_led_y`=1, `out_led_g`=0).
- R6: When disabled, `out_led_y` is 1 in slots 0 to 2 and 0 in slots 3 to 5, and `out_led_g` is 0.
- R7: On an over-temperature warning, the output lamp is yellow in slots 0 to 3 and green in slots 4 and 5.
- R8: On a fan warning, the output lamp is yellow in slots 0 to 2 and green in slots 3 to 5.
- R9: In normal operation, the output lamp is solid green.
- R10: Slot timing follows these rules:
  - A slot lasts `SLOT_TICKS` ticks, and a tick lasts `TICK_DIV` clocks.
  - Slots run 0 to 5 and then wrap to 0.
  - An input change that alters either lamp's selected indication appears one clock later, in slot 0, and the count restarts from there.
- R11: `out_led_g` and `out_led_y` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_active | input | 1 | Bootloader running |
| in_range | input | 1 | Input line within operating range |
| in_fault | input | 1 | Input undervoltage or overvoltage |
| dis_cause | input | N_DIS | Output disable causes (kill pins, enable pin high, bus off command) |
| out_of_reg | input | 1 | An output is out of regulation |
| shut_cause | input | N_SHUT | Latched shutdown causes |
| ot_warn | input | 1 | Over-temperature warning |
| fan_warn | input | 1 | Minor fan regulation error or one fan blocked |
| in_led_g | output | 1 | Input lamp green drive |
| out_led_g | output | 1 | Output lamp green drive |
| out_led_y | output | 1 | Output lamp yellow drive |

## Verification
The hardest situation to reach from the ports is a pattern that restarts part-way through a period. To see whether the restart happened, the new pattern must differ from the continued old phase at the moment of the switch. The bench holds the over-temperature pattern until it reaches slot 3. It then switches to the fan warning: if the phase restarts, the lamp must show yellow, whereas a continued phase would show green. An arithmetic model in the bench, counting clocks since the last indication change, predicts every sample. That model covers an exhaustive sweep over all 16384 input combinations and full two-period traces of each pattern.

// File: rtl/led_pkg.sv
package led_pkg;

  localparam int SLOTS_PER_PERIOD = 6;
  localparam int SLOT_W           = 3;
  localparam int BLINK_ON_SLOTS   = 3;
  localparam int OTW_YELLOW_SLOTS = 4;

  typedef logic [SLOT_W-1:0] slot_t;

  typedef enum logic [2:0] {
    IND_DARK = 3'd0,
    IND_BOOT = 3'd1,
    IND_SHUT = 3'd2,
    IND_DIS  = 3'd3,
    IND_OTW  = 3'd4,
    IND_FAN  = 3'd5,
    IND_NORM = 3'd6
  } out_ind_e;

  typedef enum logic [1:0] {
    INL_DARK  = 2'd0,
    INL_ON    = 2'd1,
    INL_BLINK = 2'd2
  } in_ind_e;

  typedef struct packed {
    logic in_g;
    logic out_g;
    logic out_y;
  } led_drive_t;

endpackage

// File: rtl/led_rst_sync.sv
module led_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
  parameter int TICK_DIV = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);

  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    if (restart || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/led_phase_seq.sv
module led_phase_seq
  import led_pkg::*;
#(
  parameter int SLOT_TICKS = 167
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  restart,
  input  logic  tick,
  output slot_t slot
);

  localparam int TW = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
  localparam logic [TW-1:0] TC_LAST   = TW'(SLOT_TICKS - 1);
  localparam slot_t         SLOT_LAST = SLOT_W'(SLOTS_PER_PERIOD - 1);

  logic [TW-1:0] tc_q, tc_d;
  slot_t         slot_q, slot_d;
  logic          adv_en;

  assign adv_en = restart | tick;

  always_comb begin
    tc_d   = tc_q;
    slot_d = slot_q;
    if (restart) begin
      tc_d   = '0;
      slot_d = '0;
    end else if (tc_q == TC_LAST) begin
      tc_d   = '0;
      slot_d = (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
    end else begin
      tc_d   = tc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q   <= '0;
      slot_q <= '0;
    end else if (adv_en) begin
      tc_q   <= tc_d;
      slot_q <= slot_d;
    end
  end

  assign slot = slot_q;

endmodule

// File: rtl/led_priority_sel.sv
module led_priority_sel
  import led_pkg::*;
#(
  parameter int N_DIS  = 3,
  parameter int N_SHUT = 5
) (
  input  logic              boot_active,
  input  logic              in_range,
  input  logic              in_fault,
  input  logic [N_DIS-1:0]  dis_cause,
  input  logic              out_of_reg,
  input  logic [N_SHUT-1:0] shut_cause,
  input  logic              ot_warn,
  input  logic              fan_warn,
  output out_ind_e          out_ind,
  output in_ind_e           in_ind
);

  logic line_ok;
  logic disabled;

  assign line_ok  = in_range & ~in_fault;
  assign disabled = (|dis_cause) | out_of_reg | ~line_ok;

  always_comb begin
    if (boot_active)      out_ind = IND_BOOT;
    else if (|shut_cause) out_ind = IND_SHUT;
    else if (disabled)    out_ind = IND_DIS;
    else if (ot_warn)     out_ind = IND_OTW;
    else if (fan_warn)    out_ind = IND_FAN;
    else                  out_ind = IND_NORM;
  end

  always_comb begin
    if (boot_active)  in_ind = INL_BLINK;
    else if (line_ok) in_ind = INL_ON;
    else              in_ind = INL_DARK;
  end

endmodule

// File: rtl/led_pattern_map.sv
module led_pattern_map
  import led_pkg::*;
(
  input  out_ind_e   out_ind,
  input  in_ind_e    in_ind,
  input  slot_t      slot,
  output led_drive_t drive
);

  logic early_half;
  logic otw_yellow;

  assign early_half = (slot < SLOT_W'(BLINK_ON_SLOTS));
  assign otw_yellow = (slot < SLOT_W'(OTW_YELLOW_SLOTS));

  always_comb begin
    drive.out_g = 1'b0;
    drive.out_y = 1'b0;
    case (out_ind)
      IND_BOOT: drive.out_g = early_half;
      IND_SHUT: drive.out_y = 1'b1;
      IND_DIS:  drive.out_y = early_half;
      IND_OTW: begin
        drive.out_y = otw_yellow;
        drive.out_g = ~otw_yellow;
      end
      IND_FAN: begin
        drive.out_y = early_half;
        drive.out_g = ~early_half;
      end
      IND_NORM: drive.out_g = 1'b1;
      default: begin
        drive.out_g = 1'b0;
        drive.out_y = 1'b0;
      end
    endcase
  end

  always_comb begin
    case (in_ind)
      INL_ON:    drive.in_g = 1'b1;
      INL_BLINK: drive.in_g = early_half;
      default:   drive.in_g = 1'b0;
    endcase
  end

endmodule

// File: rtl/panel_led_encoder.sv
module panel_led_encoder
  import led_pkg::*;
#(
  parameter int TICK_DIV   = 200000,
  parameter int SLOT_TICKS = 167,
  parameter int N_DIS      = 3,
  parameter int N_SHUT     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_active,
  input  logic              in_range,
  input  logic              in_fault,
  input  logic [N_DIS-1:0]  dis_cause,
  input  logic              out_of_reg,
  input  logic [N_SHUT-1:0] shut_cause,
  input  logic              ot_warn,
  input  logic              fan_warn,
  output logic              in_led_g,
  output logic              out_led_g,
  output logic              out_led_y
);

  logic       rst_q_n;
  out_ind_e   out_ind_d, out_ind_q;
  in_ind_e    in_ind_d, in_ind_q;
  logic       restart;
  logic       tick;
  slot_t      slot;
  led_drive_t drive;

  led_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  led_priority_sel #(.N_DIS(N_DIS), .N_SHUT(N_SHUT)) u_sel (
    .boot_active (boot_active),
    .in_range    (in_range),
    .in_fault    (in_fault),
    .dis_cause   (dis_cause),
    .out_of_reg  (out_of_reg),
    .shut_cause  (shut_cause),
    .ot_warn     (ot_warn),
    .fan_warn    (fan_warn),
    .out_ind     (out_ind_d),
    .in_ind      (in_ind_d)
  );

  assign restart = (out_ind_d != out_ind_q) | (in_ind_d != in_ind_q);

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_ind_q <= IND_DARK;
      in_ind_q  <= INL_DARK;
    end else if (restart) begin
      out_ind_q <= out_ind_d;
      in_ind_q  <= in_ind_d;
    end
  end

  led_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .restart (restart),
    .tick    (tick)
  );

  led_phase_seq #(.SLOT_TICKS(SLOT_TICKS)) u_phase (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .restart (restart),
    .tick    (tick),
    .slot    (slot)
  );

  led_pattern_map u_map (
    .out_ind (out_ind_q),
    .in_ind  (in_ind_q),
    .slot    (slot),
    .drive   (drive)
  );

  assign in_led_g  = drive.in_g;
  assign out_led_g = drive.out_g;
  assign out_led_y = drive.out_y;

endmodule

// File: rtl/led_encoder_chk.sv
module led_encoder_chk #(
  parameter int N_DIS  = 3,
  parameter int N_SHUT = 5
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              boot_active,
  input logic              in_range,
  input logic              in_fault,
  input logic [N_DIS-1:0]  dis_cause,
  input logic              out_of_reg,
  input logic [N_SHUT-1:0] shut_cause,
  input logic              ot_warn,
  input logic              fan_warn,
  input logic              in_led_g,
  input logic              out_led_g,
  input logic              out_led_y
);

  logic is_dis;
  assign is_dis = (|dis_cause) | out_of_reg | in_fault | ~in_range;

  // R11
  no_dual_color_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(out_led_g && out_led_y));

  // R5
  shut_solid_yellow_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!boot_active && (|shut_cause)) |=> (out_led_y && !out_led_g));

  // R9
  normal_green_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!boot_active && !(|shut_cause) && !is_dis && !ot_warn && !fan_warn)
      |=> (out_led_g && !out_led_y));

  // R3
  in_led_on_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!boot_active && in_range && !in_fault) |=> in_led_g);

  // R3
  in_led_off_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!boot_active && !(in_range && !in_fault)) |=> !in_led_g);

  // R4
  boot_no_yellow_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    boot_active |=> !out_led_y);

  // R6
  disabled_no_green_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!boot_active && !(|shut_cause) && is_dis) |=> !out_led_g);

endmodule

bind panel_led_encoder led_encoder_chk #(.N_DIS(N_DIS), .N_SHUT(N_SHUT)) u_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .boot_active (boot_active),
  .in_range    (in_range),
  .in_fault    (in_fault),
  .dis_cause   (dis_cause),
  .out_of_reg  (out_of_reg),
  .shut_cause  (shut_cause),
  .ot_warn     (ot_warn),
  .fan_warn    (fan_warn),
  .in_led_g    (in_led_g),
  .out_led_g   (out_led_g),
  .out_led_y   (out_led_y)
);

// File: tb/tb_panel_led_encoder.sv
`timescale 1ns/1ps
module tb_panel_led_encoder;

  localparam int TICK_DIV   = 4;
  localparam int SLOT_TICKS = 2;
  localparam int N_DIS      = 3;
  localparam int N_SHUT     = 5;
  localparam int SLOT_CYC   = TICK_DIV * SLOT_TICKS;
  localparam int PERIOD_CYC = 6 * SLOT_CYC;

  localparam int M_DARK = 0, M_BOOT = 1, M_SHUT = 2, M_DIS = 3,
                 M_OTW = 4, M_FAN = 5, M_NORM = 6;
  localparam int MI_DARK = 0, MI_ON = 1, MI_BLINK = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic boot_active, in_range, in_fault, out_of_reg, ot_warn, fan_warn;
  logic [N_DIS-1:0]  dis_cause;
  logic [N_SHUT-1:0] shut_cause;
  logic in_led_g, out_led_g, out_led_y;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  panel_led_encoder #(
    .TICK_DIV(TICK_DIV), .SLOT_TICKS(SLOT_TICKS), .N_DIS(N_DIS), .N_SHUT(N_SHUT)
  ) dut (
    .clk(clk), .rst_n(rst_n), .boot_active(boot_active), .in_range(in_range),
    .in_fault(in_fault), .dis_cause(dis_cause), .out_of_reg(out_of_reg),
    .shut_cause(shut_cause), .ot_warn(ot_warn), .fan_warn(fan_warn),
    .in_led_g(in_led_g), .out_led_g(out_led_g), .out_led_y(out_led_y)
  );

  always #2.5 clk = ~clk;

  // Reference model built from the requirements
  function automatic int want_out();
    if (boot_active) return M_BOOT;
    if (|shut_cause) return M_SHUT;
    if ((|dis_cause) || out_of_reg || in_fault || !in_range) return M_DIS;
    if (ot_warn) return M_OTW;
    if (fan_warn) return M_FAN;
    return M_NORM;
  endfunction

  function automatic int want_in();
    if (boot_active) return MI_BLINK;
    if (in_range && !in_fault) return MI_ON;
    return MI_DARK;
  endfunction

  logic [1:0] m_rs;
  int m_out, m_in, m_cyc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_rs <= 2'b00;
    else        m_rs <= {m_rs[0], 1'b1};
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !m_rs[1]) begin
      m_out <= M_DARK; m_in <= MI_DARK; m_cyc <= 0;
    end else if (want_out() != m_out || want_in() != m_in) begin
      m_out <= want_out(); m_in <= want_in(); m_cyc <= 0;
    end else begin
      m_cyc <= m_cyc + 1;
    end
  end

  function automatic string req_of(int ind);
    case (ind)
      M_BOOT: return "R4";
      M_SHUT: return "R5";
      M_DIS:  return "R6";
      M_OTW:  return "R7";
      M_FAN:  return "R8";
      M_NORM: return "R9";
      default: return "R1";
    endcase
  endfunction

  task automatic check_leds(string ctx);
    int s;
    logic eg, ey, ei;
    s  = (m_cyc / SLOT_CYC) % 6;
    eg = 1'b0; ey = 1'b0;
    case (m_out)
      M_BOOT: eg = (s < 3);
      M_SHUT: ey = 1'b1;
      M_DIS:  ey = (s < 3);
      M_OTW:  begin ey = (s < 4); eg = (s >= 4); end
      M_FAN:  begin ey = (s < 3); eg = (s >= 3); end
      M_NORM: eg = 1'b1;
      default: ;
    endcase
    ei = (m_in == MI_ON) || (m_in == MI_BLINK && s < 3);
    checks++;
    if (out_led_g !== eg || out_led_y !== ey) begin
      fails++;
      $display("FAIL %s %s output lamp slot %0d: got g=%b y=%b expected g=%b y=%b",
               ctx, req_of(m_out), s, out_led_g, out_led_y, eg, ey);
    end
    checks++;
    if (in_led_g !== ei) begin
      fails++;
      $display("FAIL %s %s input lamp slot %0d: got %b expected %b",
               ctx, (m_in == MI_BLINK) ? "R4" : "R3", s, in_led_g, ei);
    end
    checks++;
    if (out_led_g === 1'b1 && out_led_y === 1'b1) begin
      fails++;
      $display("FAIL %s R11 both colours: got g=1 y=1 expected at most one", ctx);
    end
  endtask

  task automatic check_lit(string req, logic g, logic y, logic i, logic eg, logic ey, logic ei);
    checks++;
    if (g !== eg || y !== ey || i !== ei) begin
      fails++;
      $display("FAIL %s: got g=%b y=%b in=%b expected g=%b y=%b in=%b",
               req, g, y, i, eg, ey, ei);
    end
  endtask

  // bit map: 0 boot, 1 in_range, 2 in_fault, 5:3 dis, 6 oor, 11:7 shut, 12 ot, 13 fan
  task automatic drive_vec(logic [13:0] v);
    boot_active = v[0];
    in_range    = v[1];
    in_fault    = v[2];
    dis_cause   = v[5:3];
    out_of_reg  = v[6];
    shut_cause  = v[11:7];
    ot_warn     = v[12];
    fan_warn    = v[13];
  endtask

  localparam logic [13:0] V_NORM = 14'h0002;
  localparam logic [13:0] V_BOOT = 14'h0003;
  localparam logic [13:0] V_SHUT = 14'h0082;
  localparam logic [13:0] V_DIS  = 14'h000A;
  localparam logic [13:0] V_OTW  = 14'h1002;
  localparam logic [13:0] V_FAN  = 14'h2002;

  initial begin
    logic [13:0] pats [6];
    pats[0] = V_BOOT; pats[1] = V_SHUT; pats[2] = V_DIS;
    pats[3] = V_OTW;  pats[4] = V_FAN;  pats[5] = V_NORM;

    rst_n = 1'b0;
    drive_vec(14'h0000);
    // R1: dark while reset is held
    repeat (3) begin
      @(negedge clk);
      check_lit("R1 in reset", out_led_g, out_led_y, in_led_g, 1'b0, 1'b0, 1'b0);
    end
    drive_vec(V_NORM);
    rst_n = 1'b1;
    @(negedge clk);
    check_lit("R1 after first edge", out_led_g, out_led_y, in_led_g, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check_lit("R1 after second edge", out_led_g, out_led_y, in_led_g, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check_lit("R1 R9 after third edge", out_led_g, out_led_y, in_led_g, 1'b1, 1'b0, 1'b1);

    // R2: exhaustive sweep of every input combination
    for (int i = 0; i < 16384; i++) begin
      drive_vec(14'(i));
      @(negedge clk);
      check_leds("R2 sweep");
    end

    // R10: full two-period trace of each pattern from its restart
    for (int p = 0; p < 6; p++) begin
      drive_vec((pats[p] == V_SHUT) ? V_NORM : V_SHUT);
      @(negedge clk);
      drive_vec(pats[p]);
      for (int c = 0; c < 2 * PERIOD_CYC; c++) begin
        @(negedge clk);
        check_leds("R10 pattern");
      end
    end

    // R10: restart in mid period (slot 3 would be green without restart)
    drive_vec(V_OTW);
    for (int c = 0; c < 3 * SLOT_CYC + 1; c++) begin
      @(negedge clk);
      check_leds("R10 hold");
    end
    drive_vec(V_FAN);
    @(negedge clk);
    check_lit("R10 restart to slot 0", out_led_g, out_led_y, in_led_g, 1'b0, 1'b1, 1'b1);
    check_leds("R10 restart");
    for (int c = 0; c < PERIOD_CYC; c++) begin
      @(negedge clk);
      check_leds("R10 after restart");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R10: got no completion expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule